// File: doc/BRIEF.md
# Reset-Time Link Mode Detector

After reset, a keyboard controller must learn whether it is wired for a single keyboard or for a keyboard plus a pointing device. The two wirings differ in one way. In the dual-device wiring, an external path carries the controller's keyboard data output back to its keyboard data input. In the single-keyboard wiring, the input only has a pull-up.

This block looks for that loop. It first waits until the data input has stayed high for a settle interval. The interval is counted from reset release or from the moment the input goes high, whichever comes later. It then drives a repeating probe on the data output: a high phase followed by a low phase. If the input is seen low during a low phase, the loop exists and the result is the dual-device mode. If no such low is seen before a long timeout, the result is the single-keyboard mode.

All intervals are counted in microsecond ticks. The ticks come from a prescaler whose divide ratio is an input, so the same timing holds for any system clock. The result and a done flag hold until the next reset.

Top module: `link_mode_detect`

## Requirements
- R1: While reset is asserted and after it is released, `done` reads 0, `mode_dual` reads 0 and `probe_out` reads 1 until a decision is made. `mode_dual` is never 1 while `done` is 0.
- R2: Probing begins only after the synchronised `kbd_din` has been 1 for `START_US` consecutive ticks. Any 0 on `kbd_din` restarts that count.
- R3: Each high phase of the probe (`probe_out`=1 while probing) lasts exactly `HI_US` ticks.
- R4: Each low phase of the probe lasts exactly `LO_US` ticks. The probe then returns to a high phase.
- R5: A synchronised `kbd_din` of 0, sampled on a tick during a low phase, ends detection with `done`=1 and `mode_dual`=1 (the dual-device mode). Probing stops at once.
- R6: If no loop is seen, `done` rises with `mode_dual`=0 (the single-keyboard mode) on the `TMO_US`-th tick after probing began.
- R7: If a loop sample and the timeout fall on the same tick, the loop wins and `mode_dual`=1.
- R8: Once `done` is 1, it stays 1, `mode_dual` does not change and `probe_out` stays 1 until reset.
- R9: One tick spans `clk_per_us` clock cycles. A `clk_per_us` of 0 acts as 1.
- R10: A 0 on `kbd_din` that is seen only during high phases has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_per_us | input | DIV_W | Clock cycles per microsecond tick |
| kbd_din | input | 1 | Keyboard data input line (asynchronous) |
| probe_out | output | 1 | Keyboard data output carrying the probe; idles high |
| mode_dual | output | 1 | 1 = dual-device mode, 0 = single-keyboard mode |
| done | output | 1 | Decision made; result valid |

## Verification
The loop-detection sample and the timeout expiry can land on the same tick. This happens when the last timeout tick falls inside a low phase.

The bench sets the parameters so that the final timeout tick is in a low phase. It then pulls the data input low exactly three clock cycles before that tick. The synchroniser carries the low to the decision logic on that tick and no earlier. A correct design reports the dual-device mode at exactly the timeout instant. A design that gives the timeout priority reports the single-keyboard mode.

// File: rtl/lmd_pkg.sv
// Shared types for the link mode detector.
package lmd_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_HI     = 2'd1,
        ST_LO     = 2'd2,
        ST_DONE   = 2'd3
    } lmd_state_e;
endpackage

// File: rtl/lmd_tick.sv
// Microsecond tick prescaler.
// Emits a one-cycle pulse every `div` clock cycles.
// Assumes div is held steady outside reset; a div of 0 is treated as 1.
module lmd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // Terminal count of the divider; 0 and 1 both mean every cycle.
    assign last = (div == '0) ? '0 : div - 1'b1;

    // Free-running divider producing the registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // Two ticks are never adjacent unless the ratio is one.
    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && last != '0) |=> !tick);
endmodule

// File: rtl/lmd_sync.sv
// Two-stage synchroniser for the asynchronous keyboard data input.
// Resets to 0, so the input counts as not yet released.
module lmd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic s1;

    // Double-register the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            dout <= 1'b0;
        end else begin
            s1   <= din;
            dout <= s1;
        end
    end
endmodule

// File: rtl/lmd_fsm.sv
// Probe sequencer and decision logic.
// Waits for a settled high input, drives high/low probe phases, and decides
// the link mode from a loop sample or from the timeout.
// Assumes din_s is already synchronised and tick is a one-cycle pulse.
module lmd_fsm
    import lmd_pkg::*;
#(
    parameter int START_US = 1000,
    parameter int HI_US    = 220,
    parameter int LO_US    = 220,
    parameter int TMO_US   = 64000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din_s,
    output logic probe_out,
    output logic done,
    output logic mode_dual
);
    localparam int MX1 = (START_US > HI_US) ? START_US : HI_US;
    localparam int MX  = (MX1 > LO_US) ? MX1 : LO_US;
    localparam int CW  = $clog2(MX + 1);
    localparam int TW  = $clog2(TMO_US + 1);

    lmd_state_e    state;
    logic [CW-1:0] cnt;
    logic [TW-1:0] tmo;
    logic          mode_q;
    logic          tmo_last;

    // The current tick is the last one before the timeout.
    assign tmo_last = (tmo == TW'(TMO_US - 1));

    // Phase sequencing, interval counting and the mode decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_SETTLE;
            cnt    <= '0;
            tmo    <= '0;
            mode_q <= 1'b0;
        end else begin
            case (state)
                ST_SETTLE: begin
                    if (!din_s) begin
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == CW'(START_US - 1)) begin
                            state <= ST_HI;
                            cnt   <= '0;
                            tmo   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_HI: begin
                    if (tick) begin
                        tmo <= tmo + 1'b1;
                        if (tmo_last) begin
                            state <= ST_DONE;
                        end else if (cnt == CW'(HI_US - 1)) begin
                            state <= ST_LO;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_LO: begin
                    if (tick) begin
                        tmo <= tmo + 1'b1;
                        if (!din_s) begin
                            state  <= ST_DONE;
                            mode_q <= 1'b1;
                        end else if (tmo_last) begin
                            state <= ST_DONE;
                        end else if (cnt == CW'(LO_US - 1)) begin
                            state <= ST_HI;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign probe_out = (state != ST_LO);
    assign done      = (state == ST_DONE);
    assign mode_dual = mode_q;

    // The decision is sticky until reset.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(mode_dual)));
    // The probe is released once decided.
    p_probe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> probe_out);
    // No mode claim without a decision.
    p_mode_needs_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dual |-> done);
    // The dual-device result is only taken after a low sample.
    p_dual_from_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_dual) |-> !$past(din_s));
    // Phase changes follow the prescaled tick.
    p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(probe_out) |-> $past(tick));
    // The timeout counter never passes its limit while undecided.
    p_tmo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (tmo < TW'(TMO_US)));
endmodule

// File: rtl/link_mode_detect.sv
// Top of the reset-time link mode detector.
// Connects the prescaler, the input synchroniser and the probe sequencer.
// Assumes clk_per_us is set for the clock frequency and held while running.
module link_mode_detect #(
    parameter int DIV_W    = 8,
    parameter int START_US = 1000,
    parameter int HI_US    = 220,
    parameter int LO_US    = 220,
    parameter int TMO_US   = 64000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_per_us,
    input  logic             kbd_din,
    output logic             probe_out,
    output logic             mode_dual,
    output logic             done
);
    logic tick;
    logic din_s;

    lmd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_per_us),
        .tick  (tick)
    );

    lmd_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (kbd_din),
        .dout  (din_s)
    );

    lmd_fsm #(
        .START_US (START_US),
        .HI_US    (HI_US),
        .LO_US    (LO_US),
        .TMO_US   (TMO_US)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .din_s     (din_s),
        .probe_out (probe_out),
        .done      (done),
        .mode_dual (mode_dual)
    );
endmodule

// File: tb/sim_link_mode_detect.sv
module sim_link_mode_detect;
    localparam int ST = 10;
    localparam int HI = 4;
    localparam int LO = 4;
    localparam int TM = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd1;
    logic       loop_en = 1'b0;
    logic       force_val = 1'b1;
    logic       probe_out, mode_dual, done;
    wire        din = loop_en ? probe_out : force_val;

    int t_now = 0;
    int errors = 0;
    int checks = 0;

    link_mode_detect #(
        .DIV_W(8), .START_US(ST), .HI_US(HI), .LO_US(LO), .TMO_US(TM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .clk_per_us(div), .kbd_din(din),
        .probe_out(probe_out), .mode_dual(mode_dual), .done(done)
    );

    always #5 clk = ~clk;

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        t_now++;
        if (t_now > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", t_now, 100000);
            summary_and_end();
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int d, input logic lvl);
        rst_n = 1'b0;
        div = 8'(d);
        loop_en = 1'b0;
        force_val = lvl;
        repeat (4) step();
        // R1: reset state
        check(done == 1'b0 && mode_dual == 1'b0 && probe_out == 1'b1, "R1 reset state",
              {29'd0, done, mode_dual, probe_out}, 1);
        rst_n = 1'b1;
    endtask

    task automatic wait_probe(input logic lvl, output int t);
        int n = 0;
        while (probe_out !== lvl && n <= 5000) begin
            step();
            n++;
        end
        if (n > 5000) check(1'b0, "probe edge timeout", n, 5000);
        t = t_now;
    endtask

    task automatic wait_done(output int t);
        int n = 0;
        while (done !== 1'b1 && n <= 5000) begin
            step();
            n++;
        end
        if (n > 5000) check(1'b0, "done timeout", n, 5000);
        t = t_now;
    endtask

    initial begin
        int t0, tf, tr, tf2, td, tg, lo_b, hi_b;
        bit held;

        // Case A: no loop, sweep prescaler ratios (R2 R3 R4 R6 R8 R9)
        for (int d = 1; d <= 4; d++) begin
            do_reset(d, 1'b1);
            t0 = t_now;
            wait_probe(1'b0, tf);
            lo_b = 3 + (ST - 1 + HI) * d;
            hi_b = 3 + (ST + HI) * d - 1;
            check(tf - t0 >= lo_b && tf - t0 <= hi_b, "R2 start delay", tf - t0, lo_b);
            wait_probe(1'b1, tr);
            check(tr - tf == LO * d, "R4 low phase width", tr - tf, LO * d);
            wait_probe(1'b0, tf2);
            check(tf2 - tr == HI * d, "R3 high phase width", tf2 - tr, HI * d);
            wait_done(td);
            check(td - tf == (TM - HI) * d, "R6 timeout instant", td - tf, (TM - HI) * d);
            check(mode_dual == 1'b0, "R6 single mode", int'(mode_dual), 0);
            held = 1'b1;
            for (int k = 0; k < 30; k++) begin
                step();
                if (!(done && !mode_dual && probe_out)) held = 1'b0;
            end
            check(held, "R8 single result held", int'(held), 1);
        end

        // Case B: loop present (R5 R8)
        for (int d = 1; d <= 4; d++) begin
            do_reset(d, 1'b1);
            loop_en = 1'b1;
            wait_probe(1'b0, tf);
            wait_done(td);
            check(td - tf == ((3 + d - 1) / d) * d, "R5 loop detect instant",
                  td - tf, ((3 + d - 1) / d) * d);
            check(mode_dual == 1'b1, "R5 dual mode", int'(mode_dual), 1);
            held = 1'b1;
            for (int k = 0; k < 40; k++) begin
                step();
                if (!(done && mode_dual && probe_out)) held = 1'b0;
            end
            check(held, "R8 dual result held, probing stopped", int'(held), 1);
        end

        // Case C: loop sample on the timeout tick (R7)
        do_reset(3, 1'b1);
        wait_probe(1'b0, tf);
        while (t_now < tf + (TM - HI) * 3 - 3) step();
        force_val = 1'b0;
        wait_done(td);
        check(td - tf == (TM - HI) * 3, "R7 collision instant", td - tf, (TM - HI) * 3);
        check(mode_dual == 1'b1, "R7 loop wins over timeout", int'(mode_dual), 1);

        // Case D: input held low through reset, released late, with a glitch (R2)
        do_reset(2, 1'b0);
        repeat (7) step();
        force_val = 1'b1;
        repeat (ST) step();
        force_val = 1'b0;
        repeat (3) step();
        force_val = 1'b1;
        tg = t_now;
        wait_probe(1'b0, tf);
        lo_b = 3 + (ST - 1 + HI) * 2;
        hi_b = 3 + (ST + HI) * 2 - 1;
        check(tf - tg >= lo_b && tf - tg <= hi_b, "R2 restart after glitch", tf - tg, lo_b);

        // Case E: low seen only during a high phase is ignored (R10)
        do_reset(2, 1'b1);
        wait_probe(1'b0, tf);
        wait_probe(1'b1, tr);
        force_val = 1'b0;
        while (t_now < tr + HI * 2 - 3) step();
        force_val = 1'b1;
        wait_done(td);
        check(mode_dual == 1'b0, "R10 high-phase low ignored", int'(mode_dual), 0);
        check(td - tf == (TM - HI) * 2, "R10 timeout unaffected", td - tf, (TM - HI) * 2);

        // Case F: ratio 0 acts as 1 (R9)
        do_reset(0, 1'b1);
        wait_probe(1'b0, tf);
        wait_probe(1'b1, tr);
        check(tr - tf == LO, "R9 zero ratio low width", tr - tf, LO);
        wait_probe(1'b0, tf2);
        check(tf2 - tr == HI, "R9 zero ratio high width", tf2 - tr, HI);

        summary_and_end();
    end
endmodule